// File: doc/BRIEF.md
# DTC Hysteresis and Switching Selector

This block is the decision stage of a direct-torque-control loop for a two-level voltage inverter. On each sample it compares the flux reference against the estimated flux magnitude and the torque reference against the estimated torque. A two-level comparator with memory turns the flux error into a single "raise flux" bit. A three-level comparator with memory turns the torque error into +1, 0 or -1. At the same time the flux angle is reduced to one of six 60-degree sectors.

From these three values the block picks the inverter leg state. When torque demand is nonzero it picks one of the six active vectors, and the choice depends on the sector. When torque demand is zero it picks a zero vector, and that zero vector alternates between all-low and all-high from sector to sector so that fewer legs switch. Every decision is registered, and it changes only on a clock edge at which the sample strobe is high. The estimators that feed the block and the dead-time logic that follows it are outside it.

Top module: `dtc_switch_select`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters its reset state: `inv_state` = 000, `flux_bit` = 0, `trq_lvl` = 00 and `sector` = 1. It keeps this state until the first edge with `sample_en` high.
- R2: All outputs and both comparator memories change only at a clock edge where `sample_en` is high, and the new values are visible after that edge. With `sample_en` low, every input change is ignored.
- R3: Let the flux error be `flux_ref - flux_est`, computed in signed arithmetic one bit wider than the inputs. `flux_bit` becomes 1 when the error is above +HB_FLUX and becomes 0 when it is below -HB_FLUX. Otherwise it keeps its value, including when the error equals either band edge.
- R4: Let the torque error be `trq_ref - trq_est`. `trq_lvl` becomes +1 (01) when the error is above +HB_TRQ and becomes -1 (11) when it is below -HB_TRQ, whatever its previous level. The code 10 never appears.
- R5: Inside the torque band, a level of +1 falls to 0 (00) only when the error is at or below zero. A level of -1 rises to 0 only when the error is at or above zero. Otherwise the level is held, and a level of 0 stays 0.
- R6: `flux_angle` is unsigned, and 2^ANG_W counts make one full turn. Boundary k (k = 0..5) is floor((2k+1)·2^ANG_W/12). An angle below boundary 0, or at or above boundary 5, is sector 1. Otherwise the sector is k+2, where k is the highest boundary the angle reaches. An angle equal to a boundary belongs to the higher sector.
- R7: `inv_state` is {leg a, leg b, leg c}. With `flux_bit` = 1 and torque +1, sectors 1..6 give 110, 010, 011, 001, 101, 100. With `flux_bit` = 1 and torque -1, they give 101, 100, 110, 010, 011, 001.
- R8: With `flux_bit` = 0 and torque +1, sectors 1..6 give 010, 011, 001, 101, 100, 110. With `flux_bit` = 0 and torque -1, they give 001, 101, 100, 110, 010, 011.
- R9: With torque level 0, `inv_state` is a zero vector. With `flux_bit` = 1 it is 111 in odd sectors and 000 in even sectors. With `flux_bit` = 0 it is 000 in odd sectors and 111 in even sectors. An active vector never appears at torque 0, and a zero vector never appears at a nonzero torque level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_en | input | 1 | Sample strobe; the decision updates at edges where it is high |
| flux_ref | input | DW | Flux magnitude reference, signed |
| flux_est | input | DW | Estimated flux magnitude, signed |
| trq_ref | input | DW | Torque reference, signed |
| trq_est | input | DW | Estimated torque, signed |
| flux_angle | input | ANG_W | Flux angle, unsigned, full turn = 2^ANG_W |
| inv_state | output | 3 | Leg states {a, b, c} |
| flux_bit | output | 1 | Flux comparator state |
| trq_lvl | output | 2 | Torque level: 01 = +1, 00 = 0, 11 = -1 |
| sector | output | 3 | Flux sector, 1 to 6 |

## Verification
The bench drives the flux error to exactly plus and minus the band. A comparator that used >= would switch at these values instead of holding. It also walks the torque error from +1 down through the band to exactly zero, and from -1 up to zero. A design that drops to 0 as soon as the error re-enters the band, or that never returns to 0, would show the wrong level on `trq_lvl`. Each sector boundary is probed one count below and at the boundary, and so is the wrap from the last count of the turn back to sector 1, which catches off-by-one sector decoding. All 36 combinations of flux bit, torque level and sector are checked against the table, so a swapped leg order or a zero vector that does not alternate produces a wrong `inv_state`. Finally, inputs are changed while the strobe is low, and the bench confirms that neither the outputs nor the comparator memories move.

// File: rtl/dtc_sel_pkg.sv
package dtc_sel_pkg;

    typedef enum logic [1:0] {
        TQ_ZERO = 2'b00,
        TQ_POS  = 2'b01,
        TQ_NEG  = 2'b11
    } trq_lvl_e;

    typedef logic [2:0] sector_t;

    typedef struct packed {
        logic     flux_up;
        trq_lvl_e trq;
        sector_t  sector;
        logic [2:0] vec;
    } decision_t;

    // Angle at which sector k+1 ends: (2k+1)/12 of a full turn, rounded down.
    function automatic longint sector_bound(input int k, input int aw);
        return ((2 * longint'(k) + 1) <<< aw) / 12;
    endfunction

    // Active vectors in counter-clockwise order, index 0 is the 100 vector.
    function automatic logic [2:0] active_vec(input int idx);
        case (idx)
            0:       return 3'b100;
            1:       return 3'b110;
            2:       return 3'b010;
            3:       return 3'b011;
            4:       return 3'b001;
            default: return 3'b101;
        endcase
    endfunction

    // Vector choice: step ahead or back from the sector by one or two
    // positions; zero vector alternates with sector parity.
    function automatic logic [2:0] pick_vec(input logic flux_up,
                                            input trq_lvl_e trq,
                                            input sector_t sec);
        int idx;
        int step;
        idx  = int'(sec) - 1;
        step = 0;
        case (trq)
            TQ_POS:  step = flux_up ? 1 : 2;
            TQ_NEG:  step = flux_up ? 5 : 4;
            default: step = 0;
        endcase
        if (trq == TQ_ZERO)
            return (((idx % 2) == 0) == flux_up) ? 3'b111 : 3'b000;
        return active_vec((idx + step) % 6);
    endfunction

endpackage

// File: rtl/dtc_flux_hyst.sv
module dtc_flux_hyst #(
    parameter int DW = 16,
    parameter int HB = 100
) (
    input  logic signed [DW-1:0] ref_i,
    input  logic signed [DW-1:0] est_i,
    input  logic                 prev_i,
    output logic                 next_o
);
    localparam logic signed [DW:0] BAND = (DW+1)'(HB);

    logic signed [DW:0] err;

    assign err = $signed({ref_i[DW-1], ref_i}) - $signed({est_i[DW-1], est_i});

    always_comb begin
        next_o = prev_i;
        if (err > BAND)
            next_o = 1'b1;
        else if (err < -BAND)
            next_o = 1'b0;
    end
endmodule

// File: rtl/dtc_torque_hyst.sv
module dtc_torque_hyst
    import dtc_sel_pkg::*;
#(
    parameter int DW = 16,
    parameter int HB = 200
) (
    input  logic signed [DW-1:0] ref_i,
    input  logic signed [DW-1:0] est_i,
    input  trq_lvl_e             prev_i,
    output trq_lvl_e             next_o
);
    localparam logic signed [DW:0] BAND = (DW+1)'(HB);
    localparam logic signed [DW:0] ZERO = '0;

    logic signed [DW:0] err;

    assign err = $signed({ref_i[DW-1], ref_i}) - $signed({est_i[DW-1], est_i});

    always_comb begin
        next_o = prev_i;
        if (err > BAND)
            next_o = TQ_POS;
        else if (err < -BAND)
            next_o = TQ_NEG;
        else if (prev_i == TQ_POS && err <= ZERO)
            next_o = TQ_ZERO;
        else if (prev_i == TQ_NEG && err >= ZERO)
            next_o = TQ_ZERO;
    end
endmodule

// File: rtl/dtc_sector_dec.sv
module dtc_sector_dec
    import dtc_sel_pkg::*;
#(
    parameter int ANG_W = 16
) (
    input  logic [ANG_W-1:0] angle_i,
    output sector_t          sector_o
);
    localparam int NSEC = 6;

    logic [NSEC-1:0] crossed;
    int              n_crossed;

    for (genvar k = 0; k < NSEC; k++) begin : g_bound
        localparam logic [ANG_W-1:0] BND = ANG_W'(sector_bound(k, ANG_W));
        assign crossed[k] = (angle_i >= BND);
    end

    assign n_crossed = $countones(crossed);
    assign sector_o  = (n_crossed == NSEC) ? 3'd1 : 3'(n_crossed + 1);
endmodule

// File: rtl/dtc_switch_select.sv
module dtc_switch_select
    import dtc_sel_pkg::*;
#(
    parameter int DW      = 16,
    parameter int ANG_W   = 16,
    parameter int HB_FLUX = 100,
    parameter int HB_TRQ  = 200
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_en,
    input  logic [DW-1:0]    flux_ref,
    input  logic [DW-1:0]    flux_est,
    input  logic [DW-1:0]    trq_ref,
    input  logic [DW-1:0]    trq_est,
    input  logic [ANG_W-1:0] flux_angle,
    output logic [2:0]       inv_state,
    output logic             flux_bit,
    output logic [1:0]       trq_lvl,
    output logic [2:0]       sector
);
    decision_t q;
    decision_t d;
    logic      flux_nx;
    trq_lvl_e  trq_nx;
    sector_t   sec_nx;

    dtc_flux_hyst #(.DW(DW), .HB(HB_FLUX)) i_flux (
        .ref_i  (flux_ref),
        .est_i  (flux_est),
        .prev_i (q.flux_up),
        .next_o (flux_nx)
    );

    dtc_torque_hyst #(.DW(DW), .HB(HB_TRQ)) i_trq (
        .ref_i  (trq_ref),
        .est_i  (trq_est),
        .prev_i (q.trq),
        .next_o (trq_nx)
    );

    dtc_sector_dec #(.ANG_W(ANG_W)) i_sec (
        .angle_i  (flux_angle),
        .sector_o (sec_nx)
    );

    always_comb begin
        d.flux_up = flux_nx;
        d.trq     = trq_nx;
        d.sector  = sec_nx;
        d.vec     = pick_vec(flux_nx, trq_nx, sec_nx);
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '{flux_up: 1'b0, trq: TQ_ZERO, sector: 3'd1, vec: 3'b000};
        else if (sample_en)
            q <= d;
    end

    assign inv_state = q.vec;
    assign flux_bit  = q.flux_up;
    assign trq_lvl   = q.trq;
    assign sector    = q.sector;

    // Errors rebuilt at the ports for the checks below.
    localparam logic signed [DW:0] FB = (DW+1)'(HB_FLUX);
    localparam logic signed [DW:0] TB = (DW+1)'(HB_TRQ);
    logic signed [DW:0] ferr_w;
    logic signed [DW:0] terr_w;
    assign ferr_w = $signed({flux_ref[DW-1], flux_ref}) - $signed({flux_est[DW-1], flux_est});
    assign terr_w = $signed({trq_ref[DW-1], trq_ref}) - $signed({trq_est[DW-1], trq_est});

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (inv_state == 3'b000 && !flux_bit && trq_lvl == 2'b00 && sector == 3'd1));

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> ($stable(inv_state) && $stable(flux_bit) && $stable(trq_lvl) && $stable(sector)));

    // R3
    flux_set_chk: assert property (@(posedge clk) disable iff (rst)
        (sample_en && ferr_w > FB) |=> flux_bit);

    // R3
    flux_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (sample_en && ferr_w < -FB) |=> !flux_bit);

    // R4
    trq_pos_chk: assert property (@(posedge clk) disable iff (rst)
        (sample_en && terr_w > TB) |=> trq_lvl == 2'b01);

    // R4
    trq_neg_chk: assert property (@(posedge clk) disable iff (rst)
        (sample_en && terr_w < -TB) |=> trq_lvl == 2'b11);

    // R4
    trq_code_chk: assert property (@(posedge clk) disable iff (rst)
        trq_lvl != 2'b10);

    // R6
    sector_range_chk: assert property (@(posedge clk) disable iff (rst)
        (sector >= 3'd1 && sector <= 3'd6));

    // R9
    zero_vec_pairing_chk: assert property (@(posedge clk) disable iff (rst)
        (trq_lvl == 2'b00) == (inv_state == 3'b000 || inv_state == 3'b111));
endmodule

// File: tb/test_dtc_switch_select.sv
module test_dtc_switch_select;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DW = 16;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sample_en = 1'b0;
    logic [DW-1:0] flux_ref = '0;
    logic [DW-1:0] flux_est = '0;
    logic [DW-1:0] trq_ref = '0;
    logic [DW-1:0] trq_est = '0;
    logic [AW-1:0] flux_angle = '0;
    logic [2:0]    inv_state;
    logic          flux_bit;
    logic [1:0]    trq_lvl;
    logic [2:0]    sector;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dtc_switch_select #(.DW(DW), .ANG_W(AW), .HB_FLUX(100), .HB_TRQ(200)) i_dtc_switch_select (
        .clk        (clk),
        .rst        (rst),
        .sample_en  (sample_en),
        .flux_ref   (flux_ref),
        .flux_est   (flux_est),
        .trq_ref    (trq_ref),
        .trq_est    (trq_est),
        .flux_angle (flux_angle),
        .inv_state  (inv_state),
        .flux_bit   (flux_bit),
        .trq_lvl    (trq_lvl),
        .sector     (sector)
    );

    // Expected vectors: [flux bit][torque: 0=+1, 1=0, 2=-1][sector-1]
    localparam logic [2:0] EXP_VEC [2][3][6] = '{
        '{ '{3'b010, 3'b011, 3'b001, 3'b101, 3'b100, 3'b110},
           '{3'b000, 3'b111, 3'b000, 3'b111, 3'b000, 3'b111},
           '{3'b001, 3'b101, 3'b100, 3'b110, 3'b010, 3'b011} },
        '{ '{3'b110, 3'b010, 3'b011, 3'b001, 3'b101, 3'b100},
           '{3'b111, 3'b000, 3'b111, 3'b000, 3'b111, 3'b000},
           '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001} }
    };
    localparam logic [1:0] EXP_TL [3] = '{2'b01, 2'b00, 2'b11};

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive(input int fr, input int fe, input int tr, input int te, input int ang);
        flux_ref   = 16'(fr);
        flux_est   = 16'(fe);
        trq_ref    = 16'(tr);
        trq_est    = 16'(te);
        flux_angle = 16'(ang);
    endtask

    task automatic smp(input int fr, input int fe, input int tr, input int te, input int ang);
        @(negedge clk);
        drive(fr, fe, tr, te, ang);
        sample_en = 1'b1;
        @(negedge clk);
        sample_en = 1'b0;
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state, also held across idle cycles
        chk("R1 vec", inv_state, 0);
        chk("R1 flux", flux_bit, 0);
        chk("R1 trq", trq_lvl, 0);
        chk("R1 sector", sector, 1);
        drive(5000, 0, 5000, 0, 20000);
        repeat (3) @(negedge clk);
        chk("R1 idle vec", inv_state, 0);
        chk("R1 idle sector", sector, 1);

        // R7 R8 R9 full table walk
        for (int f = 0; f < 2; f++)
            for (int t = 0; t < 3; t++)
                for (int s = 0; s < 6; s++) begin
                    smp(2000, f ? 1000 : 3000, 0, (t == 0) ? -1000 : (t == 1 ? 0 : 1000),
                        (s * 65536) / 6);
                    chk(f ? "R7 table vec" : "R8 table vec", inv_state, EXP_VEC[f][t][s]);
                    chk("R9 table flux", flux_bit, f);
                    chk("R4 table trq", trq_lvl, EXP_TL[t]);
                    chk("R6 table sector", sector, s + 1);
                end

        // R3 flux hysteresis, starting from flux bit 0
        smp(0, 200, 0, 0, 0);
        chk("R3 clear", flux_bit, 0);
        smp(100, 0, 0, 0, 0);
        chk("R3 at +band holds 0", flux_bit, 0);
        smp(101, 0, 0, 0, 0);
        chk("R3 above band sets", flux_bit, 1);
        chk("R9 flux1 odd zero", inv_state, 7);
        smp(0, 100, 0, 0, 0);
        chk("R3 at -band holds 1", flux_bit, 1);
        smp(0, 0, 0, 0, 0);
        chk("R3 zero holds 1", flux_bit, 1);
        smp(0, 101, 0, 0, 0);
        chk("R3 below band clears", flux_bit, 0);
        chk("R9 flux0 odd zero", inv_state, 0);
        smp(50, 0, 0, 0, 0);
        chk("R3 inside holds 0", flux_bit, 0);

        // R4 R5 torque hysteresis, starting from level 0
        smp(0, 0, 200, 0, 0);
        chk("R4 at +band stays 0", trq_lvl, 0);
        smp(0, 0, 201, 0, 0);
        chk("R4 above band +1", trq_lvl, 1);
        smp(0, 0, 100, 0, 0);
        chk("R5 inside holds +1", trq_lvl, 1);
        smp(0, 0, 1, 0, 0);
        chk("R5 small positive holds +1", trq_lvl, 1);
        smp(0, 0, 0, 0, 0);
        chk("R5 zero error drops to 0", trq_lvl, 0);
        smp(0, 0, 0, 150, 0);
        chk("R5 zero holds inside band", trq_lvl, 0);
        smp(0, 0, 0, 201, 0);
        chk("R4 below band -1", trq_lvl, 3);
        smp(0, 0, 0, 50, 0);
        chk("R5 inside holds -1", trq_lvl, 3);
        smp(0, 0, 0, 1, 0);
        chk("R5 small negative holds -1", trq_lvl, 3);
        smp(0, 0, 0, 0, 0);
        chk("R5 zero error rises to 0", trq_lvl, 0);
        smp(0, 0, 0, 300, 0);
        smp(0, 0, 1000, 0, 0);
        chk("R4 direct -1 to +1", trq_lvl, 1);
        smp(0, 0, 0, 5, 0);
        chk("R5 recross below zero drops", trq_lvl, 0);

        // R6 sector boundaries and wrap
        for (int k = 0; k < 6; k++) begin
            int b;
            b = ((2 * k + 1) * 65536) / 12;
            smp(2000, 1000, 1000, 0, b - 1);
            chk("R6 below boundary", sector, k + 1);
            smp(2000, 1000, 1000, 0, b);
            chk("R6 at boundary", sector, ((k + 1) % 6) + 1);
        end
        smp(2000, 1000, 1000, 0, 65535);
        chk("R6 top of turn", sector, 1);
        chk("R7 top of turn vec", inv_state, 3'b110);

        // R2 inputs ignored while strobe is low
        smp(2000, 1000, 1000, 0, 0);
        @(negedge clk);
        drive(0, 3000, 0, 1000, 30000);
        repeat (3) @(negedge clk);
        chk("R2 vec held", inv_state, 3'b110);
        chk("R2 flux held", flux_bit, 1);
        chk("R2 trq held", trq_lvl, 1);
        chk("R2 sector held", sector, 1);
        smp(0, 0, 100, 0, 0);
        chk("R2 flux memory untouched", flux_bit, 1);
        chk("R2 trq memory untouched", trq_lvl, 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule